// File: doc/BRIEF.md
# Presettable Countdown Timer with Shared Interrupt

This block is a programmable binary down-counter for a real-time-clock subsystem. A slow source clock from an external divider advances it. The source clock is brought into the system clock domain, and each of its falling edges becomes a single-cycle tick. While the counter is enabled, each tick lowers the live count by one. When the count reaches zero, a sticky event flag is set. Software clears the flag by writing zero to it.

Software reaches the block through a small byte-wide register interface with a write strobe and a combinational read port. A mode bit selects what happens at zero. In one-shot mode the counter stops at zero, clears its own enable and holds the interrupt active until the flag is cleared. In repeat mode the counter reloads from the preset and keeps running, and the interrupt is active for one source-clock period. The interrupt output is an active-low drive enable, where 1 means high impedance. An externally gated alarm request also drives it.

Register map (byte-wide, `addr` selects):
- Address 0, control: bit 0 is the event flag, bit 1 is the run enable, bit 2 is the interrupt enable, and bit 3 is the mode (0 one-shot, 1 repeat). The upper bits read as 0.
- Address 1 is the preset low byte and address 2 is the preset high byte. Both can be read and written.
- Address 3 is the live count low byte and address 4 is the live count high byte. Both are read-only.
- Any other address reads as 0.

Top module: `tmr_countdown`

## Requirements
- R1: After reset the control byte, preset and live count all read 0, and `irqDrvN` is 1.
- R2: A write to address 1 or 2 updates that byte of the preset and at once loads the whole new preset into the live count. A write to address 3 or 4 changes neither the count nor the preset.
- R3: While the run enable (control bit 1) is 1, the count drops by exactly one per falling edge of `srcClk`. No decrement happens between the write that sets the enable and the next falling edge. With the enable at 0 the count holds.
- R4: In one-shot mode (control bit 3 = 0), a decrement to zero sets the flag, clears the enable and leaves the count at 0. With the interrupt enable (control bit 2) set, `irqDrvN` is then 0 until the flag is cleared.
- R5: In repeat mode (control bit 3 = 1), a decrement to zero sets the flag and reloads the count from the preset, and the count keeps running. `irqDrvN` is 0 from that event until the next source falling edge, and then returns to 1 while the flag stays set.
- R6: Writing 0 to control bit 0 clears the flag. Writing 1 to it leaves the flag as it was.
- R7: While the interrupt enable is 0, a timer event sets the flag but never drives `irqDrvN` low.
- R8: A preset write that loads a zero count while the enable is already 1 produces no flag and no interrupt.
- R9: While `alarmIrq` is 1, `irqDrvN` is 0 whatever the timer's interrupt enable holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcClk | input | 1 | Slow source clock; falling edges drive the count |
| addr | input | ADDR_W | Register address |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr` (combinational) |
| alarmIrq | input | 1 | Alarm interrupt request, already gated by its own enable |
| irqDrvN | output | 1 | Interrupt drive enable, active low; 1 means high impedance |

## Verification
Every cycle, the checker confirms that the flag never clears without a zero write to it, that a disabled counter holds unless the preset is written, and that a one-shot event leaves the count at zero with the enable cleared. It also checks that a zero count loaded while enabled never raises the flag, that a masked timer leaves the pin released, and that the alarm always pulls the pin. Other behaviours can only be shown by the bench's directed scenarios. These are the alignment of the first decrement to the next source falling edge, the one-source-period length of the repeat-mode pulse, the reload value, and the read-only nature of the count bytes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Strobes from the control section to the datapath
  typedef struct packed {
    logic wrLo;    // preset low byte write
    logic wrHi;    // preset high byte write
    logic reload;  // repeat-mode reload of the count
    logic dec;     // decrement the count by one
  } dpStrobe_t;

  localparam int unsigned A_CTRL     = 0;
  localparam int unsigned A_PRESET_L = 1;
  localparam int unsigned A_PRESET_H = 2;
  localparam int unsigned A_COUNT_L  = 3;
  localparam int unsigned A_COUNT_H  = 4;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic srcClk,
  output logic fallTick
);
  // STAGES synchroniser flops plus one history flop
  logic [STAGES:0] shift;

  always_ff @(posedge clk) begin
    if (!rstN) shift <= '1;
    else       shift <= {shift[STAGES-1:0], srcClk};
  end

  assign fallTick = shift[STAGES] & ~shift[STAGES-1];
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [DATA_W-1:0]   wrData,
  output logic [2*DATA_W-1:0] presetVal,
  output logic [2*DATA_W-1:0] countVal,
  output logic                countIsOne,
  output logic                countIsZero
);
  localparam int CNT_W = 2 * DATA_W;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presetVal <= '0;
      countVal  <= '0;
    end else if (strobe.wrLo) begin
      presetVal[DATA_W-1:0] <= wrData;
      countVal <= {presetVal[CNT_W-1:DATA_W], wrData};
    end else if (strobe.wrHi) begin
      presetVal[CNT_W-1:DATA_W] <= wrData;
      countVal <= {wrData, presetVal[DATA_W-1:0]};
    end else if (strobe.reload) begin
      countVal <= presetVal;
    end else if (strobe.dec) begin
      countVal <= countVal - CNT_W'(1);
    end
  end

  assign countIsOne  = (countVal == CNT_W'(1));
  assign countIsZero = (countVal == '0);
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       ctrlWr,
  input  logic [3:0] ctrlBits,
  input  logic       wrLo,
  input  logic       wrHi,
  input  logic       countIsOne,
  input  logic       countIsZero,
  input  logic       alarmIrq,
  output logic       flag,
  output logic       enable,
  output logic       irqEn,
  output logic       mode,
  output dpStrobe_t  strobe,
  output logic       irqDrvN
);
  logic run, hit, presetWr, pulse;

  assign presetWr = wrLo | wrHi;
  assign run      = tick & enable;
  // Count reaches zero through a decrement (never through a preset write)
  assign hit      = run & countIsOne & ~presetWr;

  always_comb begin
    strobe.wrLo   = wrLo;
    strobe.wrHi   = wrHi;
    strobe.reload = hit & mode;
    strobe.dec    = run & ~countIsZero & ~(hit & mode);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag   <= 1'b0;
      enable <= 1'b0;
      irqEn  <= 1'b0;
      mode   <= 1'b0;
      pulse  <= 1'b0;
    end else begin
      flag <= hit | (flag & ~(ctrlWr & ~ctrlBits[0]));
      if (ctrlWr) begin
        enable <= ctrlBits[1];
        irqEn  <= ctrlBits[2];
        mode   <= ctrlBits[3];
      end else if (hit && !mode) begin
        enable <= 1'b0;
      end
      if (hit && mode) pulse <= 1'b1;
      else if (tick)   pulse <= 1'b0;
    end
  end

  assign irqDrvN = ~((irqEn & ((flag & ~mode) | pulse)) | alarmIrq);
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown
  import tmr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srcClk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              alarmIrq,
  output logic              irqDrvN
);
  localparam int CNT_W = 2 * DATA_W;

  logic tick, ctrlWr, wrLo, wrHi, presetWr;
  logic ctrlFlag, ctrlEn, ctrlIrqEn, ctrlMode;
  logic countIsOne, countIsZero;
  logic [CNT_W-1:0] presetVal, countVal;
  dpStrobe_t strobe;

  assign ctrlWr   = wrEn && (addr == ADDR_W'(A_CTRL));
  assign wrLo     = wrEn && (addr == ADDR_W'(A_PRESET_L));
  assign wrHi     = wrEn && (addr == ADDR_W'(A_PRESET_H));
  assign presetWr = wrLo | wrHi;

  tmr_edge #(.STAGES(SYNC_STAGES)) uEdge (
    .clk(clk), .rstN(rstN), .srcClk(srcClk), .fallTick(tick)
  );

  tmr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .ctrlWr(ctrlWr),
    .ctrlBits(wrData[3:0]), .wrLo(wrLo), .wrHi(wrHi),
    .countIsOne(countIsOne), .countIsZero(countIsZero),
    .alarmIrq(alarmIrq), .flag(ctrlFlag), .enable(ctrlEn),
    .irqEn(ctrlIrqEn), .mode(ctrlMode), .strobe(strobe),
    .irqDrvN(irqDrvN)
  );

  tmr_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .presetVal(presetVal), .countVal(countVal),
    .countIsOne(countIsOne), .countIsZero(countIsZero)
  );

  always_comb begin
    case (addr)
      ADDR_W'(A_CTRL):     rdData = DATA_W'({ctrlMode, ctrlIrqEn, ctrlEn, ctrlFlag});
      ADDR_W'(A_PRESET_L): rdData = presetVal[DATA_W-1:0];
      ADDR_W'(A_PRESET_H): rdData = presetVal[CNT_W-1:DATA_W];
      ADDR_W'(A_COUNT_L):  rdData = countVal[DATA_W-1:0];
      ADDR_W'(A_COUNT_H):  rdData = countVal[CNT_W-1:DATA_W];
      default:             rdData = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlWr,
  input logic             ctrlBit0,
  input logic             presetWr,
  input logic             alarmIrq,
  input logic             irqDrvN,
  input logic             flag,
  input logic             enable,
  input logic             irqEn,
  input logic             mode,
  input logic [CNT_W-1:0] countVal
);
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    flag && !(ctrlWr && !ctrlBit0) |=> flag); // R6

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable && !presetWr |=> $stable(countVal)); // R3

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) && !mode && !$past(ctrlWr) |-> (countVal == '0) && !enable); // R4

  AST_ZERO_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (countVal == '0) && enable && !presetWr |=> !$rose(flag)); // R8

  AST_MASK_TIMER: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn && !alarmIrq |-> irqDrvN); // R7

  AST_ALARM_PULLS: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> !irqDrvN); // R9
endmodule

bind tmr_countdown tmr_checker #(.CNT_W(2 * DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlBit0(wrData[0]),
  .presetWr(presetWr), .alarmIrq(alarmIrq), .irqDrvN(irqDrvN),
  .flag(ctrlFlag), .enable(ctrlEn), .irqEn(ctrlIrqEn), .mode(ctrlMode),
  .countVal(countVal)
);

// File: tb/sim_tmr_countdown.sv
module sim_tmr_countdown;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       srcClk = 1'b1;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       alarmIrq = 1'b0;
  logic       irqDrvN;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  tmr_countdown u0 (
    .clk(clk), .rstN(rstN), .srcClk(srcClk), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .alarmIrq(alarmIrq), .irqDrvN(irqDrvN)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 3'(a); wrData = 8'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr = 3'(a);
    #1;
    d = int'(rdData);
  endtask

  task automatic srcFall();
    srcClk = 1'b0;
    repeat (8) @(negedge clk);
    srcClk = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic readCount(output int c);
    int lo, hi;
    rd(3, lo); rd(4, hi);
    c = (hi << 8) | lo;
  endtask

  task automatic testReset();
    int v;
    rd(0, v); check("R1", "control", v, 0);
    rd(1, v); check("R1", "preset lo", v, 0);
    readCount(v); check("R1", "count", v, 0);
    check("R1", "irqDrvN", int'(irqDrvN), 1);
  endtask

  task automatic testPreset();
    int v;
    wr(1, 8'h34); wr(2, 8'h12);
    readCount(v); check("R2", "count after preset", v, 16'h1234);
    rd(2, v); check("R2", "preset hi readback", v, 8'h12);
    wr(3, 8'hFF); wr(4, 8'hFF);
    readCount(v); check("R2", "count after ro write", v, 16'h1234);
    rd(1, v); check("R2", "preset lo after ro write", v, 8'h34);
    repeat (3) srcFall();
    readCount(v); check("R3", "count held while disabled", v, 16'h1234);
  endtask

  task automatic testStartStop();
    int v;
    wr(2, 0); wr(1, 5);
    wr(0, 8'h02);
    repeat (20) @(negedge clk);
    readCount(v); check("R3", "no decrement before edge", v, 5);
    srcFall();
    readCount(v); check("R3", "first decrement", v, 4);
    srcFall();
    readCount(v); check("R3", "second decrement", v, 3);
    wr(0, 8'h00);
    srcFall();
    readCount(v); check("R3", "stopped count", v, 3);
  endtask

  task automatic testOneShot();
    int v;
    wr(1, 3); wr(0, 8'h06);
    srcFall(); srcFall();
    readCount(v); check("R4", "count before zero", v, 1);
    check("R4", "irq before zero", int'(irqDrvN), 1);
    srcFall();
    readCount(v); check("R4", "count at zero", v, 0);
    rd(0, v); check("R4", "control after event", v, 8'h05);
    check("R4", "irq held", int'(irqDrvN), 0);
    srcFall(); srcFall();
    readCount(v); check("R4", "count stays zero", v, 0);
    check("R4", "irq still held", int'(irqDrvN), 0);
    wr(0, 8'h05);
    rd(0, v); check("R6", "flag after writing 1", v, 8'h05);
    check("R6", "irq after writing 1", int'(irqDrvN), 0);
    wr(0, 8'h04);
    rd(0, v); check("R6", "flag after writing 0", v, 8'h04);
    check("R4", "irq released after clear", int'(irqDrvN), 1);
  endtask

  task automatic testMask();
    int v;
    wr(1, 2); wr(0, 8'h02);
    srcFall();
    srcFall();
    rd(0, v); check("R7", "flag set while masked", v, 8'h01);
    check("R7", "irq while masked", int'(irqDrvN), 1);
    wr(0, 8'h00);
  endtask

  task automatic testRepeat();
    int v;
    wr(1, 3); wr(0, 8'h0E);
    srcFall(); srcFall();
    check("R5", "irq before event", int'(irqDrvN), 1);
    srcFall();
    readCount(v); check("R5", "reloaded count", v, 3);
    rd(0, v); check("R5", "control after event", v, 8'h0F);
    check("R5", "irq pulse", int'(irqDrvN), 0);
    srcFall();
    readCount(v); check("R5", "count continues", v, 2);
    check("R5", "irq released after one period", int'(irqDrvN), 1);
    rd(0, v); check("R5", "flag retained", v, 8'h0F);
    wr(0, 8'h00);
  endtask

  task automatic testZeroLoad();
    int v;
    wr(0, 8'h0E);
    wr(1, 0);
    repeat (3) srcFall();
    rd(0, v); check("R8", "no flag on zero load", v, 8'h0E);
    check("R8", "no irq on zero load", int'(irqDrvN), 1);
    readCount(v); check("R8", "count stays zero", v, 0);
    wr(0, 8'h00);
  endtask

  task automatic testAlarm();
    @(negedge clk);
    alarmIrq = 1'b1;
    #1;
    check("R9", "alarm pulls pin", int'(irqDrvN), 0);
    @(negedge clk);
    alarmIrq = 1'b0;
    #1;
    check("R9", "pin released after alarm", int'(irqDrvN), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testPreset();
    testStartStop();
    testOneShot();
    testMask();
    testRepeat();
    testZeroLoad();
    testAlarm();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule